// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Match Alarms

This block is a memory-mapped real-time clock that counts elapsed seconds. A one-cycle tick input, produced elsewhere once per second, advances a 32-bit up-counter by one and a companion down-counter by one in the opposite direction. Software sees both counters, two alarm compare registers, a control register, a write-one-to-clear status register and a free 32-bit signature register through a simple single-cycle register bus. Reads are combinational on the bus data output during the cycle the access is presented. Writes take effect at the next clock edge.

Each compare register is checked against the up-counter on every clock cycle. While they are equal, the matching status flag is set. This includes the cycle in which software clears the flag, so an alarm that is still due reappears at once. Parking a compare register at all ones switches its comparator off. Either alarm can also latch a wake flag that drives a power-on request output, and a control bit can force that output high. The interrupt output combines each alarm flag with its own enable bit.

To set the time, software sets the freeze bit, loads the up-counter with the time and the down-counter with its complement, and then clears the freeze bit. A soft-reset control bit holds both counters and every status flag at zero. It leaves the compare registers and the signature register untouched, which lets firmware tell a clock that has already been set up from one that has just powered up.

Top module: `sec_rtc`

## Requirements
- R1: After hardware reset, the counters, control, status and signature registers read 0, both compare registers read 0xFFFFFFFF, and irq_o and pwr_on_o are low.
- R2: Byte offsets are 0x00 up-counter, 0x04 down-counter, 0x08 compare 0, 0x0C compare 1, 0x10 control, 0x14 status and 0x18 signature. Any other offset reads 0, and a write to it changes no register.
- R3: On a cycle with tick_i high while control bit 6 (freeze) and control bit 4 (soft reset) are both clear, the up-counter increments by 1 and the down-counter decrements by 1. Both counters wrap modulo 2^32.
- R4: While freeze (bit 6) is set, ticks do not change either counter, and writes to offsets 0x00 and 0x04 load the written value. While freeze is clear, writes to those offsets are ignored.
- R5: While soft reset (control bit 4) is set, both counters are held at 0 and all status bits are held at 0. The compare registers are unaffected.
- R6: Status bit 0 (bit 1) is set on the clock edge that follows any cycle in which the up-counter equals compare 0 (compare 1) and that compare register is not 0xFFFFFFFF. An equality that is still present overrides a clear written in the same cycle.
- R7: Writing 1 to a status bit (bit 0, bit 1, or bit 2 for wake) clears that bit, and writing 0 leaves it unchanged.
- R8: irq_o is high exactly when (status bit 0 and control bit 0) or (status bit 1 and control bit 1) is true.
- R9: Status bit 2 (wake) latches on a compare-0 match while control bit 2 is set, or on a compare-1 match while control bit 3 is set. pwr_on_o is high when control bit 7 is set or status bit 2 is set.
- R10: The signature register at 0x18 stores all 32 written bits and keeps its value while soft reset is active.
- R11: Control bit 5 and bits 31:8 always read 0. Bits 0 to 4, 6 and 7 read back the value last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_i | input | 1 | One-cycle seconds tick, synchronous to clk |
| bus_en_i | input | 1 | Register access valid this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte offset of the access |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, valid in the same cycle as a read access, 0 otherwise |
| irq_o | output | 1 | Alarm interrupt request |
| pwr_on_o | output | 1 | Power-on request output |

## Verification
The properties assume that tick_i is a pulse already synchronous to clk and that bus signals stay stable across each rising edge. They also assume that soft reset is only released by a write that keeps the counters consistent. The bench changes every input two nanoseconds after a rising edge and holds it for whole cycles. It issues at most one bus access per cycle and sets the freeze bit before it loads a counter. It waits several cycles after reset is released before it drives any tick or access, so the internally synchronised reset has settled before stimulus begins.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  // Register byte offsets; software depends on these positions.
  localparam int OFS_UP    = 'h00;
  localparam int OFS_DOWN  = 'h04;
  localparam int OFS_CMP0  = 'h08;
  localparam int OFS_CMP1  = 'h0C;
  localparam int OFS_CTRL  = 'h10;
  localparam int OFS_STAT  = 'h14;
  localparam int OFS_SIG   = 'h18;

  // Control register bit positions.
  localparam int CB_IRQ_EN0  = 0;
  localparam int CB_IRQ_EN1  = 1;
  localparam int CB_WAKE0    = 2;
  localparam int CB_WAKE1    = 3;
  localparam int CB_SOFT_RST = 4;
  localparam int CB_FREEZE   = 6;
  localparam int CB_FORCE_PO = 7;

  localparam int CTRL_W = 8;
  localparam logic [CTRL_W-1:0] CTRL_RW_MASK = 8'hDF;

  // Number of compare channels fixed by the register map.
  localparam int NUM_CMP = 2;
endpackage

// File: rtl/rtc_rst_sync.sv
module rtc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/rtc_cnt_pair.sv
module rtc_cnt_pair #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_i,
  input  logic         step_i,
  input  logic         load_up_i,
  input  logic         load_dn_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] up_o,
  output logic [W-1:0] dn_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] up_q, up_d;
  logic [W-1:0] dn_q, dn_d;

  always_comb begin
    up_d = up_q;
    dn_d = dn_q;
    if (clear_i) begin
      up_d = '0;
      dn_d = '0;
    end else begin
      if (load_up_i)   up_d = load_val_i;
      else if (step_i) up_d = up_q + ONE;
      if (load_dn_i)   dn_d = load_val_i;
      else if (step_i) dn_d = dn_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= '0;
      dn_q <= '0;
    end else begin
      up_q <= up_d;
      dn_q <= dn_d;
    end
  end

  assign up_o = up_q;
  assign dn_o = dn_q;
endmodule

// File: rtl/rtc_match_flags.sv
module rtc_match_flags #(
  parameter int W = 32,
  parameter int N = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [W-1:0]        count_i,
  input  logic [N-1:0][W-1:0] cmp_i,
  input  logic [N-1:0]        route_i,
  input  logic                clear_all_i,
  input  logic [N:0]          w1c_i,
  output logic [N-1:0]        flag_o,
  output logic                wake_o
);
  localparam logic [W-1:0] PARKED = {W{1'b1}};

  logic [N-1:0] hit;
  logic [N-1:0] flag_q, flag_d;
  logic         wake_q, wake_d;

  for (genvar k = 0; k < N; k++) begin : g_cmp
    assign hit[k] = (count_i == cmp_i[k]) && (cmp_i[k] != PARKED);
  end

  always_comb begin
    if (clear_all_i) begin
      flag_d = '0;
      wake_d = 1'b0;
    end else begin
      flag_d = (flag_q & ~w1c_i[N-1:0]) | hit;
      wake_d = (wake_q & ~w1c_i[N]) | (|(hit & route_i));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      wake_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
      wake_q <= wake_d;
    end
  end

  assign flag_o = flag_q;
  assign wake_o = wake_q;
endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              bus_en_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o,
  output logic              pwr_on_o
);
  localparam logic [DATA_W-1:0] CMP_PARK = {DATA_W{1'b1}};
  localparam int STAT_W = NUM_CMP + 1;

  logic rst_q_n;

  rtc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  // Address decode
  logic wr_en, rd_en;
  logic sel_up, sel_dn, sel_ctrl, sel_stat, sel_sig;
  logic [NUM_CMP-1:0] sel_cmp;

  assign wr_en    = bus_en_i & bus_we_i;
  assign rd_en    = bus_en_i & ~bus_we_i;
  assign sel_up   = (bus_addr_i == ADDR_W'(OFS_UP));
  assign sel_dn   = (bus_addr_i == ADDR_W'(OFS_DOWN));
  assign sel_cmp[0] = (bus_addr_i == ADDR_W'(OFS_CMP0));
  assign sel_cmp[1] = (bus_addr_i == ADDR_W'(OFS_CMP1));
  assign sel_ctrl = (bus_addr_i == ADDR_W'(OFS_CTRL));
  assign sel_stat = (bus_addr_i == ADDR_W'(OFS_STAT));
  assign sel_sig  = (bus_addr_i == ADDR_W'(OFS_SIG));

  logic wr_up, wr_dn, wr_ctrl, wr_stat, wr_key, cnt_wr_any;
  assign wr_up      = wr_en & sel_up;
  assign wr_dn      = wr_en & sel_dn;
  assign wr_ctrl    = wr_en & sel_ctrl;
  assign wr_stat    = wr_en & sel_stat;
  assign wr_key     = wr_en & sel_sig;
  assign cnt_wr_any = wr_up | wr_dn;

  // Control, compare and signature registers
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [NUM_CMP-1:0][DATA_W-1:0] match_q, match_d;
  logic [DATA_W-1:0] key_q, key_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) ctrl_d = bus_wdata_i[CTRL_W-1:0] & CTRL_RW_MASK;
    key_d = key_q;
    if (wr_key) key_d = bus_wdata_i;
  end

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp_reg
    always_comb begin
      match_d[k] = match_q[k];
      if (wr_en && sel_cmp[k]) match_d[k] = bus_wdata_i;
    end
    always_ff @(posedge clk or negedge rst_q_n) begin
      if (!rst_q_n) match_q[k] <= CMP_PARK;
      else          match_q[k] <= match_d[k];
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      ctrl_q <= '0;
      key_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      key_q  <= key_d;
    end
  end

  // Counter pair
  logic soft_rst, frozen, cnt_step, cnt_ld_ok;
  logic [DATA_W-1:0] up_cnt, dn_cnt;

  assign soft_rst  = ctrl_q[CB_SOFT_RST];
  assign frozen    = ctrl_q[CB_FREEZE];
  assign cnt_step  = tick_i & ~frozen & ~soft_rst;
  assign cnt_ld_ok = frozen & ~soft_rst;

  rtc_cnt_pair #(.W(DATA_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .clear_i    (soft_rst),
    .step_i     (cnt_step),
    .load_up_i  (wr_up & cnt_ld_ok),
    .load_dn_i  (wr_dn & cnt_ld_ok),
    .load_val_i (bus_wdata_i),
    .up_o       (up_cnt),
    .dn_o       (dn_cnt)
  );

  // Match flags and wake flag
  logic [NUM_CMP-1:0] flags;
  logic               wake_flag;
  logic [STAT_W-1:0]  w1c_mask;
  logic [STAT_W-1:0]  stat_vec;

  assign w1c_mask = wr_stat ? bus_wdata_i[STAT_W-1:0] : '0;

  rtc_match_flags #(.W(DATA_W), .N(NUM_CMP)) u_flags (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .count_i     (up_cnt),
    .cmp_i       (match_q),
    .route_i     (ctrl_q[CB_WAKE1:CB_WAKE0]),
    .clear_all_i (soft_rst),
    .w1c_i       (w1c_mask),
    .flag_o      (flags),
    .wake_o      (wake_flag)
  );

  assign stat_vec = {wake_flag, flags};

  // Outputs
  assign irq_o    = |(flags & ctrl_q[CB_IRQ_EN1:CB_IRQ_EN0]);
  assign pwr_on_o = ctrl_q[CB_FORCE_PO] | wake_flag;

  always_comb begin
    bus_rdata_o = '0;
    if (rd_en) begin
      if (sel_up)          bus_rdata_o = up_cnt;
      else if (sel_dn)     bus_rdata_o = dn_cnt;
      else if (sel_cmp[0]) bus_rdata_o = match_q[0];
      else if (sel_cmp[1]) bus_rdata_o = match_q[1];
      else if (sel_ctrl)   bus_rdata_o = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
      else if (sel_stat)   bus_rdata_o = {{(DATA_W-STAT_W){1'b0}}, stat_vec};
      else if (sel_sig)    bus_rdata_o = key_q;
    end
  end
endmodule

// File: rtl/rtc_chk.sv
module rtc_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              tick,
  input logic [7:0]        ctrl,
  input logic [DATA_W-1:0] up,
  input logic [DATA_W-1:0] down,
  input logic [DATA_W-1:0] m0,
  input logic [2:0]        stat,
  input logic [DATA_W-1:0] key,
  input logic              cnt_wr,
  input logic              key_wr,
  input logic              irq,
  input logic              pwr
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);
  localparam logic [DATA_W-1:0] ALL1 = {DATA_W{1'b1}};

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    tick && !ctrl[6] && !ctrl[4] |=> (up == $past(up) + ONE) && (down == $past(down) - ONE));

  // R4
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    ctrl[6] && !ctrl[4] && !cnt_wr |=> $stable(up) && $stable(down));

  // R5
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    ctrl[4] |=> (up == '0) && (down == '0) && (stat == '0));

  // R6
  match_latch_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (up == m0) && (m0 != ALL1) && !ctrl[4] |=> stat[0]);

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !ctrl[0] && !ctrl[1] |-> !irq);

  // R9
  force_pwr_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    ctrl[7] |-> pwr);

  // R10
  key_keep_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !key_wr |=> $stable(key));
endmodule

bind sec_rtc rtc_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_q_n (rst_q_n),
  .tick    (tick_i),
  .ctrl    (ctrl_q),
  .up      (up_cnt),
  .down    (dn_cnt),
  .m0      (match_q[0]),
  .stat    (stat_vec),
  .key     (key_q),
  .cnt_wr  (cnt_wr_any),
  .key_wr  (wr_key),
  .irq     (irq_o),
  .pwr     (pwr_on_o)
);

// File: tb/sec_rtc_tb.sv
module sec_rtc_tb;
  localparam int AW = 8;
  localparam int DW = 32;

  logic clk, rst_n, tick, en, we;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;
  logic irq, pwr;

  int checks = 0;
  int fails = 0;

  sec_rtc #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .bus_en_i(en), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_o(irq), .pwr_on_o(pwr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, got, exp, $time);
    end
  endtask

  // Behavioural reference model
  logic [DW-1:0] m_up, m_dn, m_key;
  logic [DW-1:0] m_cmp [2];
  logic [7:0]    m_ctrl;
  logic [2:0]    m_stat;

  function automatic logic [DW-1:0] model_read(input logic [AW-1:0] a);
    case (int'(a))
      'h00: return m_up;
      'h04: return m_dn;
      'h08: return m_cmp[0];
      'h0C: return m_cmp[1];
      'h10: return {24'd0, m_ctrl};
      'h14: return {29'd0, m_stat};
      'h18: return m_key;
      default: return '0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_up <= '0; m_dn <= '0; m_key <= '0; m_ctrl <= '0; m_stat <= '0;
      m_cmp[0] <= '1; m_cmp[1] <= '1;
    end else begin
      bit wr;
      bit [1:0] hit;
      wr = en && we;
      for (int k = 0; k < 2; k++) hit[k] = (m_up == m_cmp[k]) && (m_cmp[k] != 32'hFFFF_FFFF);
      if (m_ctrl[4]) begin
        m_stat <= '0; m_up <= '0; m_dn <= '0;
      end else begin
        logic [2:0] s;
        s = m_stat;
        if (wr && addr == 8'h14) s = s & ~wdata[2:0];
        s[1:0] = s[1:0] | hit;
        if ((hit[0] && m_ctrl[2]) || (hit[1] && m_ctrl[3])) s[2] = 1'b1;
        m_stat <= s;
        if (m_ctrl[6]) begin
          if (wr && addr == 8'h00) m_up <= wdata;
          if (wr && addr == 8'h04) m_dn <= wdata;
        end else if (tick) begin
          m_up <= m_up + 1;
          m_dn <= m_dn - 1;
        end
      end
      if (wr && addr == 8'h10) m_ctrl <= wdata[7:0] & 8'hDF;
      if (wr && addr == 8'h08) m_cmp[0] <= wdata;
      if (wr && addr == 8'h0C) m_cmp[1] <= wdata;
      if (wr && addr == 8'h18) m_key <= wdata;
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R8 irq_o vs model", {31'd0, irq},
          {31'd0, (m_stat[0] & m_ctrl[0]) | (m_stat[1] & m_ctrl[1])});
      chk("R9 pwr_on_o vs model", {31'd0, pwr}, {31'd0, m_ctrl[7] | m_stat[2]});
      chk("R2 rdata vs model", rdata, (en && !we) ? model_read(addr) : '0);
    end
  end

  // Stimulus tasks: every input change happens 2 ns after a rising edge
  task automatic wr_reg(input logic [AW-1:0] a, input logic [DW-1:0] d);
    en = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #2;
    en = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic rd_reg(input logic [AW-1:0] a, output logic [DW-1:0] d);
    en = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); #1;
    d = rdata;
    @(posedge clk); #2;
    en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(posedge clk); #2;
      tick = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
    end
  endtask

  task automatic expect_reg(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    logic [DW-1:0] v;
    rd_reg(a, v);
    chk(req, v, exp);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; en = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    idle(5);

    // R1 reset values
    expect_reg("R1 up", 8'h00, 32'h0);
    expect_reg("R1 down", 8'h04, 32'h0);
    expect_reg("R1 cmp0", 8'h08, 32'hFFFF_FFFF);
    expect_reg("R1 cmp1", 8'h0C, 32'hFFFF_FFFF);
    expect_reg("R1 ctrl", 8'h10, 32'h0);
    expect_reg("R1 stat", 8'h14, 32'h0);
    expect_reg("R1 sig", 8'h18, 32'h0);
    chk("R1 irq_o", {31'd0, irq}, 32'd0);
    chk("R1 pwr_on_o", {31'd0, pwr}, 32'd0);

    // R3 counting
    ticks(5);
    expect_reg("R3 up after 5", 8'h00, 32'd5);
    expect_reg("R3 down after 5", 8'h04, 32'hFFFF_FFFB);

    // R4 load while frozen, R3 wrap
    wr_reg(8'h10, 32'h40);
    wr_reg(8'h00, 32'hFFFF_FFFE);
    wr_reg(8'h04, 32'h0000_0001);
    wr_reg(8'h10, 32'h00);
    ticks(3);
    expect_reg("R3 up wrap", 8'h00, 32'd1);
    expect_reg("R3 down wrap", 8'h04, 32'hFFFF_FFFE);

    // R4 write ignored while running
    wr_reg(8'h00, 32'h1234);
    expect_reg("R4 up write ignored", 8'h00, 32'd1);

    // R4 ticks ignored while frozen
    wr_reg(8'h10, 32'h40);
    ticks(4);
    expect_reg("R4 up frozen", 8'h00, 32'd1);
    wr_reg(8'h00, 32'd10);
    wr_reg(8'h04, 32'hFFFF_FFF5);
    wr_reg(8'h10, 32'h01);

    // R6 / R8 compare 0
    wr_reg(8'h08, 32'd12);
    ticks(1);
    idle(1);
    expect_reg("R6 no match yet", 8'h14, 32'd0);
    ticks(1);
    idle(1);
    expect_reg("R6 match0 latched", 8'h14, 32'd1);
    chk("R8 irq on enabled match", {31'd0, irq}, 32'd1);

    // R7 write of zero has no effect; clear while equal re-latches
    wr_reg(8'h14, 32'd0);
    expect_reg("R7 write 0 keeps flag", 8'h14, 32'd1);
    wr_reg(8'h14, 32'd1);
    expect_reg("R6 relatch while equal", 8'h14, 32'd1);

    // R6 parked compare, R7 clear
    wr_reg(8'h08, 32'hFFFF_FFFF);
    wr_reg(8'h14, 32'd1);
    idle(1);
    expect_reg("R7 cleared and parked", 8'h14, 32'd0);
    chk("R8 irq low after clear", {31'd0, irq}, 32'd0);

    // R9 wake via compare 1, R8 irq masked
    wr_reg(8'h10, 32'h08);
    wr_reg(8'h0C, 32'd14);
    ticks(2);
    idle(1);
    expect_reg("R9 match1 and wake", 8'h14, 32'd6);
    chk("R8 irq masked for match1", {31'd0, irq}, 32'd0);
    chk("R9 pwr_on_o from wake", {31'd0, pwr}, 32'd1);
    wr_reg(8'h14, 32'd7);
    expect_reg("R6 relatch match1", 8'h14, 32'd6);
    wr_reg(8'h0C, 32'hFFFF_FFFF);
    wr_reg(8'h14, 32'd7);
    expect_reg("R7 wake cleared", 8'h14, 32'd0);
    chk("R9 pwr_on_o low", {31'd0, pwr}, 32'd0);

    // R9 forced output
    wr_reg(8'h10, 32'h80);
    idle(1);
    chk("R9 forced pwr_on_o", {31'd0, pwr}, 32'd1);
    expect_reg("R9 force sets no flag", 8'h14, 32'd0);

    // R5 / R10 soft reset
    wr_reg(8'h18, 32'hB5C1_3F27);
    wr_reg(8'h0C, 32'h55);
    wr_reg(8'h10, 32'h10);
    ticks(3);
    expect_reg("R5 up held zero", 8'h00, 32'd0);
    expect_reg("R5 down held zero", 8'h04, 32'd0);
    expect_reg("R5 stat held zero", 8'h14, 32'd0);
    expect_reg("R5 cmp1 kept", 8'h0C, 32'h55);
    expect_reg("R10 signature kept", 8'h18, 32'hB5C1_3F27);

    // R11 control read mask
    wr_reg(8'h10, 32'hFFFF_FFFF);
    expect_reg("R11 ctrl mask", 8'h10, 32'h0000_00DF);
    wr_reg(8'h10, 32'h0);
    chk("R11 pwr low after ctrl clear", {31'd0, pwr}, 32'd0);

    // R2 unmapped offsets
    wr_reg(8'h1C, 32'hA5A5_A5A5);
    wr_reg(8'h80, 32'h5A5A_5A5A);
    expect_reg("R2 unmapped 0x1C", 8'h1C, 32'd0);
    expect_reg("R2 misaligned 0x11", 8'h11, 32'd0);
    expect_reg("R2 sig untouched", 8'h18, 32'hB5C1_3F27);
    expect_reg("R2 cmp1 untouched", 8'h0C, 32'h55);
    expect_reg("R2 ctrl untouched", 8'h10, 32'd0);
    expect_reg("R2 up untouched", 8'h00, 32'd0);

    idle(3);
    finish_run();
  end
endmodule